// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Scaled Clock

The block drives four pulse-width modulated outputs. Each channel owns an 8-bit up-counter whose period and duty come from write-only registers. The counters advance on one of three single-cycle clock enables. Two base enables, A and B, arrive from outside the block. A third enable, the scaled clock S, comes from an internal prescaler. The prescaler divides enable A by an 8-bit programmable factor, where zero stands for 256, and then by two.

Channels 1 and 2 form one pair, and channels 3 and 4 form another. Each pair picks its count enable through a 2-bit field of the control register. When that field is clear, pair 1/2 counts on A and pair 3/4 counts on B. Each channel has its own polarity bit, which sets the level its output holds at the start of every period. A new period or duty value is held in a shadow register. The counter takes it over only at its next wrap, so a rewrite never produces a truncated or stretched pulse.

Top module: `pwm4_top`

## Requirements
- R1: A register write happens on a clock edge with `wr_en` high. Address 0 is control, address 1 is the prescale factor, address 2+2k is the period of channel k+1 and address 3+2k is its duty (k = 0..3). With `wr_en` low, nothing is written.
- R2: Synchronous reset clears control, prescale, all periods, duties and counters. With polarity 0 and duty 0, all four outputs are then high.
- R3: The S enable is a one-cycle pulse. It fires once per 2·N pulses of A, where N is the prescale factor and N = 0 means 256. It is issued in the cycle after the A pulse that completes the count.
- R4: Channels 1 and 2 count on S when either bit of control[5:4] is set. They count on A when both bits are clear.
- R5: Channels 3 and 4 count on S when either bit of control[7:6] is set. They count on B when both bits are clear.
- R6: A period value P gives a period of P count ticks, and P = 0 gives 256 ticks. The counter runs from 0 to P-1 and then wraps to 0.
- R7: Control bit k-1 is the polarity of channel k. When it is set, the output is high for the first D ticks of each period and low for the rest.
- R8: When the polarity bit is clear, the output is low for the first D ticks and high for the rest.
- R9: A duty of 0 holds the output at its end level for the whole period. A duty D ≥ P, with P nonzero, holds it at its start level.
- R10: Written period and duty values take effect only at the channel's next wrap. Polarity takes effect at once.
- R11: A channel output changes only in the cycle after that channel's count tick or after a change to its polarity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_a | input | 1 | Base count enable A, one cycle per tick |
| en_b | input | 1 | Base count enable B, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 4 | PWM outputs, bit k-1 for channel k |

## Verification
An output edge shows up one clock after the enable pulse that moves the counter. With enable A or B, there are no extra register stages. With S, there is one more cycle, because the S pulse is itself registered one cycle after its A pulse. Since every tick goes through the same pipeline, the bench measures high and low run lengths between output edges. It samples at the falling clock edge and compares the runs to D·T and (P−D)·T, where T is the tick spacing in clocks. Period and duty changes only take effect after the old period ends. For that reason the bench waits at least one full old period, computed from the previous settings, before it measures. The shadow-latch check watches the cycles just after a wrap for the old waveform to continue.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int AW  = 4;

    localparam logic [AW-1:0] ADDR_CTRL  = AW'(0);
    localparam logic [AW-1:0] ADDR_SCALE = AW'(1);

    typedef logic [DW-1:0] byte_t;

    // control register layout: [7:6] pair 3/4 select, [5:4] pair 1/2 select,
    // [3:0] polarity of channels 4..1
    typedef struct packed {
        logic [1:0]     sel_hi;
        logic [1:0]     sel_lo;
        logic [NCH-1:0] pol;
    } ctrl_t;

    typedef struct packed {
        byte_t period;
        byte_t duty;
    } chcfg_t;

    function automatic logic [AW-1:0] period_addr(int k);
        return AW'(2 + 2 * k);
    endfunction

    function automatic logic [AW-1:0] duty_addr(int k);
        return AW'(3 + 2 * k);
    endfunction

    function automatic logic uses_scaled(ctrl_t c, int k);
        return (k >= NCH / 2) ? (|c.sel_hi) : (|c.sel_lo);
    endfunction

endpackage

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler
    import pwm4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_a,
    input  byte_t scale,
    output logic  s_en
);

    byte_t cnt;
    logic  half;
    logic  term;

    // zero factor wraps through all 256 states
    assign term = en_a && (cnt == byte_t'(scale - byte_t'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            half <= 1'b0;
            s_en <= 1'b0;
        end else begin
            s_en <= term && half;
            if (term) begin
                cnt  <= '0;
                half <= ~half;
            end else if (en_a) begin
                cnt <= cnt + byte_t'(1);
            end
        end
    end

endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
    import pwm4_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   pol,
    input  chcfg_t cfg_new,
    output logic   pwm
);

    chcfg_t act;
    byte_t  cnt;
    logic   last;

    assign last = (cnt == byte_t'(act.period - byte_t'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            act <= '0;
        end else if (tick) begin
            if (last) begin
                cnt <= '0;
                act <= cfg_new;
            end else begin
                cnt <= cnt + byte_t'(1);
            end
        end
    end

    assign pwm = (cnt < act.duty) ? pol : ~pol;

endmodule

// File: rtl/pwm4_top.sv
module pwm4_top
    import pwm4_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en_a,
    input  logic           en_b,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_out
);

    ctrl_t          ctrl_q;
    byte_t          scale_q;
    logic           s_en;
    logic [NCH-1:0] ch_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            scale_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL)  ctrl_q  <= ctrl_t'(wr_data);
            if (wr_addr == ADDR_SCALE) scale_q <= wr_data;
        end
    end

    pwm4_prescaler u_presc (
        .clk   (clk),
        .rst   (rst),
        .en_a  (en_a),
        .scale (scale_q),
        .s_en  (s_en)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        chcfg_t shadow;
        logic   base_en;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow <= '0;
            end else if (wr_en) begin
                if (wr_addr == period_addr(k)) shadow.period <= wr_data;
                if (wr_addr == duty_addr(k))   shadow.duty   <= wr_data;
            end
        end

        if (k >= NCH / 2) begin : g_hi
            assign base_en = en_b;
        end else begin : g_lo
            assign base_en = en_a;
        end

        assign ch_tick[k] = uses_scaled(ctrl_q, k) ? s_en : base_en;

        pwm4_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (ch_tick[k]),
            .pol     (ctrl_q.pol[k]),
            .cfg_new (shadow),
            .pwm     (pwm_out[k])
        );
    end

endmodule

// File: rtl/pwm4_checker.sv
module pwm4_checker
    import pwm4_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           en_a,
    input logic           s_en,
    input logic [NCH-1:0] ch_tick,
    input logic [NCH-1:0] pwm_out,
    input logic [DW-1:0]  ctrl_bits,
    input byte_t          scale
);

    assert_s_after_a_R3: assert property (@(posedge clk) disable iff (rst)
        s_en |-> $past(en_a))
        else $error("S pulse without preceding A pulse");

    assert_s_single_R3: assert property (@(posedge clk) disable iff (rst)
        s_en |=> !s_en)
        else $error("S pulse longer than one cycle");

    assert_cfg_reset_R2: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_bits == '0 && scale == '0))
        else $error("registers not cleared by reset");

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        assert_edge_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
            !$stable(pwm_out[k]) |-> ($past(ch_tick[k]) || !$stable(ctrl_bits[k])))
            else $error("output %0d moved without tick or polarity change", k);
    end

endmodule

bind pwm4_top pwm4_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .en_a      (en_a),
    .s_en      (s_en),
    .ch_tick   (ch_tick),
    .pwm_out   (pwm_out),
    .ctrl_bits (ctrl_q),
    .scale     (scale_q)
);

// File: tb/pwm4_top_tb_top.sv
module pwm4_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_a = 1'b0;
    logic       en_b = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_out;
    logic       gate = 1'b1;

    int errors = 0;
    int checks = 0;

    localparam int KA = 2;   // clocks between A pulses
    localparam int KB = 3;   // clocks between B pulses

    always #4 clk = ~clk;    // 125 MHz

    pwm4_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .en_a    (en_a),
        .en_b    (en_b),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    initial begin
        int ca = 0;
        int cb = 0;
        forever begin
            @(negedge clk);
            ca = (ca + 1) % KA;
            cb = (cb + 1) % KB;
            en_a = gate && (ca == 0);
            en_b = gate && (cb == 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // run lengths in clocks: low run then high run after a falling edge
    task automatic measure(input int ch, output int hi, output int lo);
        int t = 0;
        hi = 0; lo = 0;
        while (pwm_out[ch] !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
        while (pwm_out[ch] !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        while (pwm_out[ch] === 1'b0 && lo < 20000) begin lo++; @(negedge clk); end
        while (pwm_out[ch] === 1'b1 && hi < 20000) begin hi++; @(negedge clk); end
    endtask

    task automatic expect_runs(input string req, input int ch, input int ehi, input int elo);
        int hi, lo;
        measure(ch, hi, lo);
        chk({req, " high run"}, hi, ehi);
        chk({req, " low run"}, lo, elo);
    endtask

    task automatic hold(input string req, input int ch, input logic lvl, input int n);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[ch] !== lvl) bad++;
        end
        chk(req, bad, 0);
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        @(negedge clk);
        // R2: polarity clear and duty zero gives high outputs
        chk("R2 reset outputs", int'(pwm_out), 15);

        // R7 R4 R6: ch1 on A, P=10 D=3, polarity set
        wr(2, 10); wr(3, 3); wr(0, 8'h01);
        idle(700);
        expect_runs("R7 ch1 A pol1", 0, 3 * KA, 7 * KA);

        // R8: polarity clear, effective at once
        wr(0, 8'h00);
        idle(50);
        expect_runs("R8 ch1 A pol0", 0, 7 * KA, 3 * KA);

        // R5: ch3 on B, P=8 D=5
        wr(6, 8); wr(7, 5); wr(0, 8'h04);
        idle(900);
        expect_runs("R5 ch3 B", 2, 5 * KB, 3 * KB);

        // R3 R4: ch2 on S, factor 1 -> tick every 2*1*KA clocks
        wr(4, 4); wr(5, 1);
        idle(600);
        wr(1, 1); wr(0, 8'h26);
        idle(100);
        expect_runs("R3 ch2 S factor1", 1, 1 * 2 * KA, 3 * 2 * KA);

        // R5: bit 6 alone moves ch3 to S
        wr(0, 8'h46);
        idle(100);
        expect_runs("R5 ch3 S via bit6", 2, 5 * 2 * KA, 3 * 2 * KA);

        // R4 R3: bit 4 alone keeps ch2 on S, factor 5
        wr(0, 8'h16); wr(1, 5); wr(5, 2);
        idle(400);
        expect_runs("R4 R3 ch2 S factor5", 1, 2 * 10 * KA, 2 * 10 * KA);

        // R3: factor 0 means 256
        wr(1, 0);
        idle(6000);
        expect_runs("R3 ch2 S factor0", 1, 2 * 512 * KA, 2 * 512 * KA);

        // R9: ch4 on B, duty 0 -> end level (low with polarity set)
        wr(0, 8'h08); wr(8, 6); wr(9, 0);
        idle(900);
        hold("R9 duty zero", 3, 1'b0, 60);
        wr(9, 6);
        idle(40);
        hold("R9 duty equal period", 3, 1'b1, 60);
        wr(9, 200);
        idle(40);
        hold("R9 duty above period", 3, 1'b1, 60);

        // R10: new values wait for the wrap
        wr(0, 8'h09); wr(2, 200); wr(3, 100);
        idle(60);
        while (pwm_out[0] !== 1'b0) @(negedge clk);
        while (pwm_out[0] !== 1'b1) @(negedge clk);
        wr(2, 10); wr(3, 3);
        hold("R10 old period kept until wrap", 0, 1'b1, 150);
        idle(500);
        expect_runs("R10 new values after wrap", 0, 3 * KA, 7 * KA);

        // R1: write with strobe low is ignored
        @(negedge clk);
        wr_addr = 4'd3; wr_data = 8'd8; wr_en = 1'b0;
        idle(3);
        idle(100);
        expect_runs("R1 ignored write", 0, 3 * KA, 7 * KA);

        // R11: no ticks, no output movement
        gate = 1'b0;
        idle(5);
        begin
            logic [3:0] snap;
            int moved = 0;
            snap = pwm_out;
            repeat (200) begin
                @(negedge clk);
                if (pwm_out !== snap) moved++;
            end
            chk("R11 still without ticks", moved, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule